// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Status

This block forms the maintenance status of a virtual interrupt interface. It reads these inputs live:
- the hypervisor's per-condition enable bits;
- the virtual machine's group 0 and group 1 enable bits;
- the two-bit state of every list register;
- the end-of-interrupt count;
- the per-list-register end-of-interrupt status vector.

From them it builds an 8-bit set of conditions inside a 32-bit status word. The word is combinational and follows its inputs in the same cycle.

A registered maintenance-interrupt level is raised when the interface global enable is set and any condition is active.

A privilege-checked read port returns the status word to software. It responds one cycle after a request, with one of three results: the data, an undefined-access flag or a trap-to-hypervisor flag.

Top module: `vmaint_status`

## Requirements
- R1: `status_o[31:8]` is always zero. The condition bits sit at these positions: bit 0 end-of-interrupt, bit 1 underflow, bit 2 entry-not-present, bit 3 no-pending, bit 4 group0-on, bit 5 group0-off, bit 6 group1-on, bit 7 group1-off.
- R2: Bit 0 is 1 whenever any bit of `eoi_vec_i` is 1. It has no enable.
- R3: Bit 1 is 1 when `cond_en_i[1]` is 1 and at most one list register is valid. List register n uses `lr_state_i[2n+1:2n]`, with encoding 00 invalid, 01 pending, 10 active, 11 pending-and-active. Any state other than 00 is valid.
- R4: Bit 2 is 1 when `cond_en_i[2]` is 1 and `eoi_count_i` is nonzero.
- R5: Bit 3 is 1 when `cond_en_i[3]` is 1 and no list register is in state 01 or 11.
- R6: Bit 4 is `cond_en_i[4]` AND `vm_grp0_en_i`. Bit 5 is `cond_en_i[5]` AND NOT `vm_grp0_en_i`.
- R7: Bit 6 is `cond_en_i[6]` AND `vm_grp1_en_i`. Bit 7 is `cond_en_i[7]` AND NOT `vm_grp1_en_i`.
- R8: `maint_irq_o` equals, one clock later, `iface_en_i` AND (any bit of `status_o` set).
- R9: A read is requested with `rd_level_i` encoded as 0 user, 1 guest kernel, 2 hypervisor, 3 monitor.
  - A user-level read is undefined.
  - A guest-kernel read traps when `trap_ctl_i` is 1, and is undefined otherwise.
- R10: A hypervisor read returns the status when `hyp_sre_i` is 1, and is undefined otherwise.
  - A monitor read returns the status when `mon_sre_i` is 1, and is undefined otherwise.
  - At each of these two levels, only that level's own enable bit is consulted.
- R11: The read response appears in the cycle after `rd_req_i`, with `rd_valid_o` high for one cycle. At most one of `rd_undef_o` and `rd_trap_o` is set, and `rd_data_o` is zero unless the read is granted. With no request, all response outputs are zero.
- R12: While `rst_ni` is low, `maint_irq_o`, `rd_valid_o`, `rd_undef_o`, `rd_trap_o` and `rd_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_en_i | input | 7 | Condition enables, bits 7:1 aligned to status bits |
| vm_grp0_en_i | input | 1 | Virtual group 0 enable |
| vm_grp1_en_i | input | 1 | Virtual group 1 enable |
| iface_en_i | input | 1 | Interface global enable |
| lr_state_i | input | 2*NUM_LR | State field of each list register |
| eoi_count_i | input | EOI_CNT_W | End-of-interrupt count |
| eoi_vec_i | input | NUM_LR | End-of-interrupt status per list register |
| status_o | output | 32 | Live maintenance status word |
| maint_irq_o | output | 1 | Registered maintenance interrupt level |
| rd_req_i | input | 1 | Read request |
| rd_level_i | input | 2 | Privilege level of the requester |
| trap_ctl_i | input | 1 | Trap guest-kernel reads to hypervisor |
| hyp_sre_i | input | 1 | Hypervisor register-access enable |
| mon_sre_i | input | 1 | Monitor register-access enable |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 32 | Read data, zero unless granted |
| rd_undef_o | output | 1 | Read is undefined |
| rd_trap_o | output | 1 | Read traps to hypervisor |

## Verification
The assertions assume that the inputs are stable at each rising clock edge and that `rd_level_i` holds a known value whenever `rd_req_i` is high. They also assume the list-register state bits are never X, because the valid count and the pending detection feed an in-line consistency check.

The stimulus meets these assumptions by changing every input only on the falling edge. It keeps each read request high for exactly one cycle, and it drives fully defined list-register patterns from the vector table.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;
  localparam int unsigned STATUS_W = 32;
  localparam int unsigned COND_W   = 8;

  localparam int unsigned ST_EOI    = 0;
  localparam int unsigned ST_UNDER  = 1;
  localparam int unsigned ST_ABSENT = 2;
  localparam int unsigned ST_NOPEND = 3;
  localparam int unsigned ST_G0ON   = 4;
  localparam int unsigned ST_G0OFF  = 5;
  localparam int unsigned ST_G1ON   = 6;
  localparam int unsigned ST_G1OFF  = 7;

  typedef enum logic [1:0] {
    LR_INVALID  = 2'b00,
    LR_PEND     = 2'b01,
    LR_ACT      = 2'b10,
    LR_PEND_ACT = 2'b11
  } lr_state_e;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } priv_lvl_e;

  typedef enum logic [1:0] {
    RD_GRANT = 2'd0,
    RD_UNDEF = 2'd1,
    RD_TRAP  = 2'd2
  } rd_verdict_e;
endpackage

// File: rtl/vmaint_lr_scan.sv
module vmaint_lr_scan
  import vmaint_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  localparam int unsigned CNT_W = $clog2(NUM_LR + 1)
) (
  input  logic [2*NUM_LR-1:0] lr_state_i,
  output logic [CNT_W-1:0]    valid_cnt_o,
  output logic                any_pend_o,
  output logic                few_valid_o
);
  logic [NUM_LR-1:0] entry_valid;
  logic [NUM_LR-1:0] entry_pend;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_entry
    lr_state_e st;
    assign st             = lr_state_e'(lr_state_i[2*g +: 2]);
    assign entry_valid[g] = (st != LR_INVALID);
    assign entry_pend[g]  = (st == LR_PEND) || (st == LR_PEND_ACT);
  end

  always_comb begin
    valid_cnt_o = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      valid_cnt_o = valid_cnt_o + CNT_W'(entry_valid[i]);
    end
    any_pend_o  = |entry_pend;
    few_valid_o = (valid_cnt_o <= CNT_W'(1));
    // R5: a pending entry is always a valid entry
    if (any_pend_o) begin
      a_r5_pend_is_valid: assert (valid_cnt_o != '0);
    end
  end
endmodule

// File: rtl/vmaint_cond.sv
module vmaint_cond
  import vmaint_pkg::*;
#(
  parameter int unsigned NUM_LR    = 4,
  parameter int unsigned EOI_CNT_W = 5
) (
  input  logic [COND_W-1:1]   cond_en_i,
  input  logic                grp0_en_i,
  input  logic                grp1_en_i,
  input  logic                few_valid_i,
  input  logic                any_pend_i,
  input  logic [EOI_CNT_W-1:0] eoi_count_i,
  input  logic [NUM_LR-1:0]   eoi_vec_i,
  output logic [STATUS_W-1:0] status_o
);
  logic [COND_W-1:0] flags;

  always_comb begin
    flags            = '0;
    flags[ST_EOI]    = |eoi_vec_i;
    flags[ST_UNDER]  = cond_en_i[ST_UNDER]  & few_valid_i;
    flags[ST_ABSENT] = cond_en_i[ST_ABSENT] & (eoi_count_i != '0);
    flags[ST_NOPEND] = cond_en_i[ST_NOPEND] & ~any_pend_i;
    flags[ST_G0ON]   = cond_en_i[ST_G0ON]   &  grp0_en_i;
    flags[ST_G0OFF]  = cond_en_i[ST_G0OFF]  & ~grp0_en_i;
    flags[ST_G1ON]   = cond_en_i[ST_G1ON]   &  grp1_en_i;
    flags[ST_G1OFF]  = cond_en_i[ST_G1OFF]  & ~grp1_en_i;
    status_o         = {{(STATUS_W-COND_W){1'b0}}, flags};
  end
endmodule

// File: rtl/vmaint_rd_gate.sv
module vmaint_rd_gate
  import vmaint_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_req_i,
  input  logic [1:0]          rd_level_i,
  input  logic                trap_ctl_i,
  input  logic                hyp_sre_i,
  input  logic                mon_sre_i,
  input  logic [STATUS_W-1:0] status_i,
  output logic                rd_valid_o,
  output logic [STATUS_W-1:0] rd_data_o,
  output logic                rd_undef_o,
  output logic                rd_trap_o
);
  rd_verdict_e verdict;

  always_comb begin
    unique case (priv_lvl_e'(rd_level_i))
      LVL_USER:   verdict = RD_UNDEF;
      LVL_KERNEL: verdict = trap_ctl_i ? RD_TRAP : RD_UNDEF;
      LVL_HYP:    verdict = hyp_sre_i ? RD_GRANT : RD_UNDEF;
      LVL_MON:    verdict = mon_sre_i ? RD_GRANT : RD_UNDEF;
      default:    verdict = RD_UNDEF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_undef_o <= 1'b0;
      rd_trap_o  <= 1'b0;
    end else begin
      rd_valid_o <= rd_req_i;
      rd_data_o  <= (rd_req_i && verdict == RD_GRANT) ? status_i : '0;
      rd_undef_o <= rd_req_i && (verdict == RD_UNDEF);
      rd_trap_o  <= rd_req_i && (verdict == RD_TRAP);
    end
  end

  a_r11_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_undef_o, rd_trap_o}));
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (!rd_undef_o && !rd_trap_o && rd_data_o == '0));
  a_r9_user_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && rd_level_i == 2'd0) |=> (rd_valid_o && rd_undef_o));
  a_r10_hyp_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && rd_level_i == 2'd2 && hyp_sre_i) |=>
      (rd_data_o == $past(status_i) && !rd_undef_o && !rd_trap_o));
endmodule

// File: rtl/vmaint_status.sv
module vmaint_status
  import vmaint_pkg::*;
#(
  parameter int unsigned NUM_LR    = 4,
  parameter int unsigned EOI_CNT_W = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [COND_W-1:1]     cond_en_i,
  input  logic                  vm_grp0_en_i,
  input  logic                  vm_grp1_en_i,
  input  logic                  iface_en_i,
  input  logic [2*NUM_LR-1:0]   lr_state_i,
  input  logic [EOI_CNT_W-1:0]  eoi_count_i,
  input  logic [NUM_LR-1:0]     eoi_vec_i,
  output logic [STATUS_W-1:0]   status_o,
  output logic                  maint_irq_o,
  input  logic                  rd_req_i,
  input  logic [1:0]            rd_level_i,
  input  logic                  trap_ctl_i,
  input  logic                  hyp_sre_i,
  input  logic                  mon_sre_i,
  output logic                  rd_valid_o,
  output logic [STATUS_W-1:0]   rd_data_o,
  output logic                  rd_undef_o,
  output logic                  rd_trap_o
);
  localparam int unsigned CNT_W = $clog2(NUM_LR + 1);

  logic [CNT_W-1:0] valid_cnt;
  logic             any_pend;
  logic             few_valid;

  vmaint_lr_scan #(.NUM_LR(NUM_LR)) u_scan (
    .lr_state_i  (lr_state_i),
    .valid_cnt_o (valid_cnt),
    .any_pend_o  (any_pend),
    .few_valid_o (few_valid)
  );

  vmaint_cond #(.NUM_LR(NUM_LR), .EOI_CNT_W(EOI_CNT_W)) u_cond (
    .cond_en_i   (cond_en_i),
    .grp0_en_i   (vm_grp0_en_i),
    .grp1_en_i   (vm_grp1_en_i),
    .few_valid_i (few_valid),
    .any_pend_i  (any_pend),
    .eoi_count_i (eoi_count_i),
    .eoi_vec_i   (eoi_vec_i),
    .status_o    (status_o)
  );

  vmaint_rd_gate u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_req_i   (rd_req_i),
    .rd_level_i (rd_level_i),
    .trap_ctl_i (trap_ctl_i),
    .hyp_sre_i  (hyp_sre_i),
    .mon_sre_i  (mon_sre_i),
    .status_i   (status_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .rd_undef_o (rd_undef_o),
    .rd_trap_o  (rd_trap_o)
  );

  // registered level keeps combinational hazards off the interrupt line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) maint_irq_o <= 1'b0;
    else         maint_irq_o <= iface_en_i && (status_o != '0);
  end

  a_r8_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (maint_irq_o == $past(iface_en_i && (status_o != '0))));
  // R3: underflow only with at most one valid entry
  a_r3_under_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_UNDER] |-> (valid_cnt <= CNT_W'(1)));
endmodule

// File: tb/vmaint_status_tb.sv
`timescale 1ns/1ps
module vmaint_status_tb_top;
  localparam int unsigned NL = 4;
  localparam int unsigned CW = 5;

  typedef struct packed {
    logic [7:0]    en;
    logic          g0;
    logic          g1;
    logic [2*NL-1:0] lr;
    logic [CW-1:0] cnt;
    logic [NL-1:0] vec;
    logic [7:0]    exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{8'h00, 1'b0, 1'b0, 8'h00, 5'd0,  4'h0, 8'h00},
    '{8'hFE, 1'b0, 1'b0, 8'h00, 5'd0,  4'h0, 8'hAA},
    '{8'hFE, 1'b1, 1'b1, 8'h55, 5'd3,  4'h2, 8'h55},
    '{8'h02, 1'b0, 1'b0, 8'h02, 5'd0,  4'h0, 8'h02},
    '{8'h02, 1'b0, 1'b0, 8'h0A, 5'd0,  4'h0, 8'h00},
    '{8'h08, 1'b0, 1'b0, 8'hAA, 5'd0,  4'h0, 8'h08},
    '{8'h08, 1'b0, 1'b0, 8'hC0, 5'd0,  4'h0, 8'h00},
    '{8'h00, 1'b0, 1'b0, 8'h00, 5'd0,  4'h8, 8'h01},
    '{8'h04, 1'b0, 1'b0, 8'h00, 5'd1,  4'h0, 8'h04},
    '{8'h04, 1'b0, 1'b0, 8'h00, 5'd31, 4'h0, 8'h04},
    '{8'h04, 1'b1, 1'b1, 8'hFF, 5'd0,  4'h0, 8'h00},
    '{8'hF0, 1'b1, 1'b0, 8'h00, 5'd0,  4'h0, 8'h90},
    '{8'hF0, 1'b0, 1'b1, 8'h00, 5'd0,  4'h0, 8'h60}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:1] cond_en = '0;
  logic g0 = 0, g1 = 0, iface_en = 0;
  logic [2*NL-1:0] lr = '0;
  logic [CW-1:0] cnt = '0;
  logic [NL-1:0] vec = '0;
  logic rd_req = 0, trap_ctl = 0, hyp_sre = 0, mon_sre = 0;
  logic [1:0] rd_level = '0;
  logic [31:0] status, rd_data;
  logic irq, rd_valid, rd_undef, rd_trap;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vmaint_status #(.NUM_LR(NL), .EOI_CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cond_en_i(cond_en),
    .vm_grp0_en_i(g0), .vm_grp1_en_i(g1), .iface_en_i(iface_en),
    .lr_state_i(lr), .eoi_count_i(cnt), .eoi_vec_i(vec),
    .status_o(status), .maint_irq_o(irq),
    .rd_req_i(rd_req), .rd_level_i(rd_level), .trap_ctl_i(trap_ctl),
    .hyp_sre_i(hyp_sre), .mon_sre_i(mon_sre),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .rd_undef_o(rd_undef), .rd_trap_o(rd_trap)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cond_en = v.en[7:1]; g0 = v.g0; g1 = v.g1; lr = v.lr; cnt = v.cnt; vec = v.vec;
  endtask

  // request at negedge, response registered at next posedge, sampled at following negedge
  task automatic do_read(input logic [1:0] lvl, input logic tc, input logic hs, input logic ms,
                         input logic exp_undef, input logic exp_trap, input logic [31:0] exp_data,
                         input string req);
    @(negedge clk);
    rd_level = lvl; trap_ctl = tc; hyp_sre = hs; mon_sre = ms; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid == 1'b1, "R11 valid", 32'(rd_valid), 32'd1);
    chk(rd_undef == exp_undef, req, 32'(rd_undef), 32'(exp_undef));
    chk(rd_trap == exp_trap, req, 32'(rd_trap), 32'(exp_trap));
    chk(rd_data == exp_data, req, rd_data, exp_data);
    @(negedge clk);
    chk(!rd_valid && !rd_undef && !rd_trap && rd_data == 0, "R11 idle", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: outputs quiet during reset despite active stimulus
    apply(VT[1]); iface_en = 1'b1; rd_req = 1'b1; rd_level = 2'd2; hyp_sre = 1'b1;
    repeat (3) @(negedge clk);
    chk(irq == 0, "R12 irq", 32'(irq), 0);
    chk(rd_valid == 0 && rd_data == 0 && !rd_undef && !rd_trap, "R12 read", rd_data, 0);
    rd_req = 1'b0;
    rst_ni = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VT[i]);
      #1;
      chk(status == {24'h0, VT[i].exp}, $sformatf("R2 R3 R4 R5 R6 R7 vec %0d", i), status, {24'h0, VT[i].exp});
      chk(status[31:8] == 0, "R1 upper", status, 0);
      @(negedge clk);
      chk(irq == (VT[i].exp != 0), "R8 irq", 32'(irq), 32'(VT[i].exp != 0));
    end

    // R8: global enable off masks interrupt
    @(negedge clk); apply(VT[1]); iface_en = 1'b0;
    @(negedge clk);
    chk(irq == 0, "R8 iface off", 32'(irq), 0);
    iface_en = 1'b1;
    @(negedge clk);
    chk(irq == 1, "R8 iface on", 32'(irq), 1);

    // R9 R10 read privilege gating, status = 0xAA
    do_read(2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,  "R9 user");
    do_read(2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0,  "R9 kernel trap");
    do_read(2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,  "R9 kernel undef");
    do_read(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hAA, "R10 hyp grant");
    do_read(2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0,  "R10 hyp undef");
    do_read(2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hAA, "R10 mon grant");
    do_read(2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,  "R10 mon undef");

    // R12: asynchronous reset mid-run clears the interrupt
    @(negedge clk); rst_ni = 1'b0; #1;
    chk(irq == 0, "R12 async", 32'(irq), 0);
    rst_ni = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule